// File: doc/BRIEF.md
# Register Forwarding Stage with Write Coalescing

This block sits between two segments of a result broadcast bus in a windowed out-of-order core. It keeps its own copy of the architectural register state: a value, the time tag of the instruction that produced it, and a flag that says whether the register has ever been written. Each cycle it takes register writes from two sources: the upstream bus segment and the local group of stations. It merges writes that target the same register. It then sends at most one update per register to the downstream segment, one cycle after the write arrived.

When a new column is loaded, the whole register image can be copied in at once from the neighbouring unit. A combinational lookup port returns the stored value, tag and written flag of any register. Backward operand requests use this port when no earlier station can supply the operand.

Time tags give the program order of the producing instructions. A larger unsigned tag means a later instruction. A write whose tag is older than the stored tag cannot replace the stored value.

Top module: `rfu_fwd_unit`

## Requirements
- R1: After reset, no register is marked written, nothing is pending, and both downstream lanes are invalid.
- R2: An accepted write is stored, and it appears on a downstream lane with its register index, tag and value in the first cycle after the one in which it was presented.
- R3: When both sources write the same register in one cycle, only the write with the larger tag is kept and forwarded, and it is forwarded once. On equal tags the local source wins.
- R4: A write whose tag is smaller than the stored tag of a written register changes neither the stored state nor the downstream lanes. A write with an equal tag is accepted.
- R5: At most two updates leave per cycle. Lane 0 carries the pending register with the smallest tag, and lane 1 carries the next smallest. Equal tags go out in ascending register index. Lane 1 is only valid when lane 0 is valid. Further pending registers wait for later cycles.
- R6: A bulk load replaces every register's value, tag and written flag, and it drops all pending updates. Writes presented in the same cycle are compared against the loaded state and are applied on top of it.
- R7: The lookup port returns, in the same cycle, the stored value, tag and written flag of the register it selects. The returned state is the state before this cycle's writes.
- R8: If a register is forwarded in the same cycle that a newer write to it arrives, that register stays pending and is forwarded again in the next cycle with the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| up_vld | input | 1 | Upstream segment write valid |
| up_idx | input | IW | Upstream write register index |
| up_tag | input | TW | Upstream write time tag |
| up_val | input | DW | Upstream write value |
| loc_vld | input | 1 | Local group write valid |
| loc_idx | input | IW | Local write register index |
| loc_tag | input | TW | Local write time tag |
| loc_val | input | DW | Local write value |
| init_load | input | 1 | Bulk load of the whole register image |
| init_val | input | NREG*DW | Loaded values, register r at bits r*DW |
| init_tag | input | NREG*TW | Loaded tags, register r at bits r*TW |
| init_known | input | NREG | Loaded written flags, bit r for register r |
| rq_idx | input | IW | Lookup register index |
| rsp_val | output | DW | Stored value of the selected register |
| rsp_tag | output | TW | Stored tag of the selected register |
| rsp_known | output | 1 | Selected register has been written |
| o0_vld | output | 1 | Downstream lane 0 valid |
| o0_idx | output | IW | Lane 0 register index |
| o0_tag | output | TW | Lane 0 time tag |
| o0_val | output | DW | Lane 0 value |
| o1_vld | output | 1 | Downstream lane 1 valid |
| o1_idx | output | IW | Lane 1 register index |
| o1_tag | output | TW | Lane 1 time tag |
| o1_val | output | DW | Lane 1 value |

## Verification
Two functions can fall on the same edge: the drain of a register that is on a downstream lane, and the arrival of a fresh write to that same register. The bench provokes this by writing a register and then, while it is on lane 0, presenting a second write to it. In one run the second write carries a later tag, and in another it carries an earlier tag. The register must reappear with the new content in the first case. In the second case nothing is forwarded, and the lookup must still return the earlier stored tag.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  // Unsigned program-order compare of two logical time tags (zero-extended).
  function automatic logic tag_not_older(input logic [31:0] cand, input logic [31:0] held);
    return cand >= held;
  endfunction
endpackage

// File: rtl/rfu_merge.sv
// Per-register merge of the two incoming write sources against the base state.
module rfu_merge import rfu_pkg::*; #(
  parameter int IW  = 5,
  parameter int TW  = 8,
  parameter int DW  = 32,
  parameter int REG = 0
) (
  input  logic          base_known,
  input  logic [TW-1:0] base_tag,
  input  logic          up_vld,
  input  logic [IW-1:0] up_idx,
  input  logic [TW-1:0] up_tag,
  input  logic [DW-1:0] up_val,
  input  logic          loc_vld,
  input  logic [IW-1:0] loc_idx,
  input  logic [TW-1:0] loc_tag,
  input  logic [DW-1:0] loc_val,
  output logic          take,
  output logic [TW-1:0] new_tag,
  output logic [DW-1:0] new_val
);
  logic hit_up, hit_loc, use_loc;

  always_comb begin
    hit_up  = up_vld && (up_idx == IW'(REG)) &&
              (!base_known || tag_not_older(32'(up_tag), 32'(base_tag)));
    hit_loc = loc_vld && (loc_idx == IW'(REG)) &&
              (!base_known || tag_not_older(32'(loc_tag), 32'(base_tag)));
    use_loc = hit_loc && (!hit_up || tag_not_older(32'(loc_tag), 32'(up_tag)));
    take    = hit_up || hit_loc;
    new_tag = use_loc ? loc_tag : up_tag;
    new_val = use_loc ? loc_val : up_val;
  end
endmodule

// File: rtl/rfu_pick.sv
// Selects the two pending registers with the smallest tags (ties: lower index).
module rfu_pick #(
  parameter int NREG = 32,
  parameter int TW   = 8,
  parameter int IW   = 5
) (
  input  logic [NREG-1:0]    pend,
  input  logic [NREG*TW-1:0] tags,
  output logic               s0_vld,
  output logic [IW-1:0]      s0_idx,
  output logic               s1_vld,
  output logic [IW-1:0]      s1_idx
);
  logic [TW-1:0] best0, best1;

  always_comb begin
    s0_vld = 1'b0;
    s0_idx = '0;
    best0  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (pend[i] && (!s0_vld || tags[i*TW +: TW] < best0)) begin
        s0_vld = 1'b1;
        s0_idx = IW'(i);
        best0  = tags[i*TW +: TW];
      end
    end
    s1_vld = 1'b0;
    s1_idx = '0;
    best1  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (pend[i] && !(s0_vld && s0_idx == IW'(i)) &&
          (!s1_vld || tags[i*TW +: TW] < best1)) begin
        s1_vld = 1'b1;
        s1_idx = IW'(i);
        best1  = tags[i*TW +: TW];
      end
    end
  end
endmodule

// File: rtl/rfu_fwd_unit.sv
module rfu_fwd_unit #(
  parameter  int NREG = 32,
  parameter  int DW   = 32,
  parameter  int TW   = 8,
  localparam int IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_vld,
  input  logic [IW-1:0]      up_idx,
  input  logic [TW-1:0]      up_tag,
  input  logic [DW-1:0]      up_val,
  input  logic               loc_vld,
  input  logic [IW-1:0]      loc_idx,
  input  logic [TW-1:0]      loc_tag,
  input  logic [DW-1:0]      loc_val,
  input  logic               init_load,
  input  logic [NREG*DW-1:0] init_val,
  input  logic [NREG*TW-1:0] init_tag,
  input  logic [NREG-1:0]    init_known,
  input  logic [IW-1:0]      rq_idx,
  output logic [DW-1:0]      rsp_val,
  output logic [TW-1:0]      rsp_tag,
  output logic               rsp_known,
  output logic               o0_vld,
  output logic [IW-1:0]      o0_idx,
  output logic [TW-1:0]      o0_tag,
  output logic [DW-1:0]      o0_val,
  output logic               o1_vld,
  output logic [IW-1:0]      o1_idx,
  output logic [TW-1:0]      o1_tag,
  output logic [DW-1:0]      o1_val
);
  // Stored register image
  logic [DW-1:0]   st_val [NREG];
  logic [TW-1:0]   st_tag [NREG];
  logic [NREG-1:0] st_known;
  logic [NREG-1:0] pend;

  // Base state (stored or bulk-loaded) and merge results
  logic [DW-1:0]   b_val [NREG];
  logic [TW-1:0]   b_tag [NREG];
  logic [NREG-1:0] b_known;
  logic [DW-1:0]   n_val [NREG];
  logic [TW-1:0]   n_tag [NREG];
  logic [NREG-1:0] take, drain, pend_n, upd_en;
  logic [NREG*TW-1:0] tag_flat;
  logic            s0_vld, s1_vld;
  logic [IW-1:0]   s0_idx, s1_idx;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      b_val[r]   = init_load ? init_val[r*DW +: DW] : st_val[r];
      b_tag[r]   = init_load ? init_tag[r*TW +: TW] : st_tag[r];
      b_known[r] = init_load ? init_known[r]        : st_known[r];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    rfu_merge #(.IW(IW), .TW(TW), .DW(DW), .REG(r)) u_merge (
      .base_known (b_known[r]),
      .base_tag   (b_tag[r]),
      .up_vld     (up_vld),
      .up_idx     (up_idx),
      .up_tag     (up_tag),
      .up_val     (up_val),
      .loc_vld    (loc_vld),
      .loc_idx    (loc_idx),
      .loc_tag    (loc_tag),
      .loc_val    (loc_val),
      .take       (take[r]),
      .new_tag    (n_tag[r]),
      .new_val    (n_val[r])
    );
    assign tag_flat[r*TW +: TW] = st_tag[r];
  end

  rfu_pick #(.NREG(NREG), .TW(TW), .IW(IW)) u_pick (
    .pend   (pend),
    .tags   (tag_flat),
    .s0_vld (s0_vld),
    .s0_idx (s0_idx),
    .s1_vld (s1_vld),
    .s1_idx (s1_idx)
  );

  // Next-state: drain the forwarded lanes, bulk load drops pending, merges set it
  always_comb begin
    drain = '0;
    if (s0_vld) drain[s0_idx] = 1'b1;
    if (s1_vld) drain[s1_idx] = 1'b1;
    pend_n = (init_load ? '0 : (pend & ~drain)) | take;
    upd_en = {NREG{init_load}} | take;
  end

  // Control state: asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_known <= '0;
      pend     <= '0;
    end else begin
      pend <= pend_n;
      for (int r = 0; r < NREG; r++)
        if (upd_en[r]) st_known[r] <= b_known[r] | take[r];
    end
  end

  // Data state: no reset, qualified by the written flag
  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (upd_en[r]) begin
        st_val[r] <= take[r] ? n_val[r] : b_val[r];
        st_tag[r] <= take[r] ? n_tag[r] : b_tag[r];
      end
    end
  end

  always_comb begin
    o0_vld    = s0_vld;
    o0_idx    = s0_idx;
    o0_tag    = st_tag[s0_idx];
    o0_val    = st_val[s0_idx];
    o1_vld    = s1_vld;
    o1_idx    = s1_idx;
    o1_tag    = st_tag[s1_idx];
    o1_val    = st_val[s1_idx];
    rsp_val   = st_val[rq_idx];
    rsp_tag   = st_tag[rq_idx];
    rsp_known = st_known[rq_idx];
  end
endmodule

// File: rtl/rfu_fwd_unit_chk.sv
module rfu_fwd_unit_chk #(
  parameter int IW = 5,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_vld,
  input logic [IW-1:0] up_idx,
  input logic [TW-1:0] up_tag,
  input logic          loc_vld,
  input logic          init_load,
  input logic [IW-1:0] rq_idx,
  input logic [TW-1:0] rsp_tag,
  input logic          rsp_known,
  input logic          o0_vld,
  input logic [IW-1:0] o0_idx,
  input logic [TW-1:0] o0_tag,
  input logic          o1_vld,
  input logic [IW-1:0] o1_idx,
  input logic [TW-1:0] o1_tag
);
  // R4: without a bulk load, a written register's tag never moves backwards
  a_r4_tag_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rq_idx) == rq_idx && $past(rsp_known) && !$past(init_load))
      |-> (rsp_known && rsp_tag >= $past(rsp_tag)));

  // R5: lane 1 only with lane 0, ordered by tag, distinct registers
  a_r5_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    o1_vld |-> (o0_vld && o0_tag <= o1_tag && o0_idx != o1_idx));

  // R6: a bulk load with no concurrent writes leaves nothing to forward
  a_r6_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_load && !up_vld && !loc_vld) |-> (!o0_vld && !o1_vld));

  // R8: a newer write to the register being drained is forwarded next cycle
  a_r8_refresh_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(o0_vld && up_vld && !loc_vld && !init_load &&
          up_idx == o0_idx && up_tag > o0_tag)
      |-> ((o0_vld && o0_idx == $past(o0_idx) && o0_tag == $past(up_tag)) ||
           (o1_vld && o1_idx == $past(o0_idx) && o1_tag == $past(up_tag))));
endmodule

bind rfu_fwd_unit rfu_fwd_unit_chk #(.IW(IW), .TW(TW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_vld    (up_vld),
  .up_idx    (up_idx),
  .up_tag    (up_tag),
  .loc_vld   (loc_vld),
  .init_load (init_load),
  .rq_idx    (rq_idx),
  .rsp_tag   (rsp_tag),
  .rsp_known (rsp_known),
  .o0_vld    (o0_vld),
  .o0_idx    (o0_idx),
  .o0_tag    (o0_tag),
  .o1_vld    (o1_vld),
  .o1_idx    (o1_idx),
  .o1_tag    (o1_tag)
);

// File: tb/test_rfu_fwd_unit.sv
`timescale 1ns/1ps
module test_rfu_fwd_unit;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int TW   = 8;
  localparam int IW   = 5;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               up_vld, loc_vld, init_load;
  logic [IW-1:0]      up_idx, loc_idx, rq_idx;
  logic [TW-1:0]      up_tag, loc_tag;
  logic [DW-1:0]      up_val, loc_val;
  logic [NREG*DW-1:0] init_val;
  logic [NREG*TW-1:0] init_tag;
  logic [NREG-1:0]    init_known;
  logic [DW-1:0]      rsp_val, o0_val, o1_val;
  logic [TW-1:0]      rsp_tag, o0_tag, o1_tag;
  logic               rsp_known, o0_vld, o1_vld;
  logic [IW-1:0]      o0_idx, o1_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rfu_fwd_unit #(.NREG(NREG), .DW(DW), .TW(TW)) i_rfu_fwd_unit (
    .clk(clk), .rst_n(rst_n),
    .up_vld(up_vld), .up_idx(up_idx), .up_tag(up_tag), .up_val(up_val),
    .loc_vld(loc_vld), .loc_idx(loc_idx), .loc_tag(loc_tag), .loc_val(loc_val),
    .init_load(init_load), .init_val(init_val), .init_tag(init_tag),
    .init_known(init_known), .rq_idx(rq_idx),
    .rsp_val(rsp_val), .rsp_tag(rsp_tag), .rsp_known(rsp_known),
    .o0_vld(o0_vld), .o0_idx(o0_idx), .o0_tag(o0_tag), .o0_val(o0_val),
    .o1_vld(o1_vld), .o1_idx(o1_idx), .o1_tag(o1_tag), .o1_val(o1_val)
  );

  typedef struct packed {
    logic uv; logic [4:0] ui; logic [7:0] ut; logic [31:0] ud;
    logic lv; logic [4:0] li; logic [7:0] lt; logic [31:0] ld;
    logic av; logic [4:0] ai; logic [7:0] at; logic [31:0] ad;
    logic bv; logic [4:0] bi; logic [7:0] bt; logic [31:0] bd;
  } vec_t;

  // upstream write | local write | expected lane 0 | expected lane 1
  localparam vec_t VEC [8] = '{
    '{1'b1, 5'd3,  8'd10, 32'hA1, 1'b0, 5'd0,  8'd0,  32'h0,
      1'b1, 5'd3,  8'd10, 32'hA1, 1'b0, 5'd0,  8'd0,  32'h0},   // R2
    '{1'b1, 5'd5,  8'd20, 32'hB1, 1'b1, 5'd5,  8'd25, 32'hC1,
      1'b1, 5'd5,  8'd25, 32'hC1, 1'b0, 5'd0,  8'd0,  32'h0},   // R3 later wins
    '{1'b1, 5'd5,  8'd21, 32'hD1, 1'b0, 5'd0,  8'd0,  32'h0,
      1'b0, 5'd0,  8'd0,  32'h0,  1'b0, 5'd0,  8'd0,  32'h0},   // R4 older dropped
    '{1'b1, 5'd7,  8'd30, 32'hE1, 1'b1, 5'd2,  8'd12, 32'hF1,
      1'b1, 5'd2,  8'd12, 32'hF1, 1'b1, 5'd7,  8'd30, 32'hE1},  // R5 order by tag
    '{1'b1, 5'd7,  8'd30, 32'h61, 1'b0, 5'd0,  8'd0,  32'h0,
      1'b1, 5'd7,  8'd30, 32'h61, 1'b0, 5'd0,  8'd0,  32'h0},   // R4 equal tag
    '{1'b1, 5'd9,  8'd35, 32'h71, 1'b1, 5'd9,  8'd35, 32'h81,
      1'b1, 5'd9,  8'd35, 32'h81, 1'b0, 5'd0,  8'd0,  32'h0},   // R3 tie to local
    '{1'b1, 5'd12, 8'd40, 32'h91, 1'b1, 5'd11, 8'd40, 32'h92,
      1'b1, 5'd11, 8'd40, 32'h92, 1'b1, 5'd12, 8'd40, 32'h91},  // R5 tie by index
    '{1'b0, 5'd0,  8'd0,  32'h0,  1'b0, 5'd0,  8'd0,  32'h0,
      1'b0, 5'd0,  8'd0,  32'h0,  1'b0, 5'd0,  8'd0,  32'h0}    // R2 idle
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_lane(input string req, input logic v, input logic [4:0] i,
                          input logic [7:0] t, input logic [31:0] d,
                          input logic ev, input logic [4:0] ei,
                          input logic [7:0] et, input logic [31:0] ed);
    chk(req, v ? {18'd0, 1'b1, i, t, d} : 64'd0,
             ev ? {18'd0, 1'b1, ei, et, ed} : 64'd0);
  endtask

  task automatic idle_in();
    up_vld = 1'b0; up_idx = '0; up_tag = '0; up_val = '0;
    loc_vld = 1'b0; loc_idx = '0; loc_tag = '0; loc_val = '0;
    init_load = 1'b0;
  endtask

  task automatic drive_up(input logic [4:0] i, input logic [7:0] t, input logic [31:0] d);
    up_vld = 1'b1; up_idx = i; up_tag = t; up_val = d;
  endtask

  task automatic lookup(input string req, input logic [4:0] i, input logic k,
                        input logic [7:0] t, input logic [31:0] d);
    rq_idx = i;
    #1;
    chk(req, rsp_known ? {23'd0, 1'b1, rsp_tag, rsp_val} : 64'd0,
             k ? {23'd0, 1'b1, t, d} : 64'd0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_in();
    rq_idx = '0;
    init_val = '0; init_tag = '0; init_known = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk_lane("R1 lane0", o0_vld, o0_idx, o0_tag, o0_val, 1'b0, 5'd0, 8'd0, 32'd0);
    chk("R1 lane1", {63'd0, o1_vld}, 64'd0);
    lookup("R1 unwritten", 5'd0, 1'b0, 8'd0, 32'd0);
    @(negedge clk);

    // Vector table: drive at negedge, sample after the following edge
    for (int v = 0; v < 8; v++) begin
      idle_in();
      up_vld = VEC[v].uv; up_idx = VEC[v].ui; up_tag = VEC[v].ut; up_val = VEC[v].ud;
      loc_vld = VEC[v].lv; loc_idx = VEC[v].li; loc_tag = VEC[v].lt; loc_val = VEC[v].ld;
      step();
      chk_lane($sformatf("R2/R3/R4/R5 vec%0d lane0", v), o0_vld, o0_idx, o0_tag, o0_val,
               VEC[v].av, VEC[v].ai, VEC[v].at, VEC[v].ad);
      chk_lane($sformatf("R5 vec%0d lane1", v), o1_vld, o1_idx, o1_tag, o1_val,
               VEC[v].bv, VEC[v].bi, VEC[v].bt, VEC[v].bd);
    end
    idle_in();

    // R7 lookups of stored state (R4: older write to r5 left it at tag 25)
    lookup("R7 r5 stored", 5'd5, 1'b1, 8'd25, 32'hC1);
    lookup("R7 r7 stored", 5'd7, 1'b1, 8'd30, 32'h61);
    lookup("R7 r0 never written", 5'd0, 1'b0, 8'd0, 32'd0);

    // R8: refresh of the register being drained
    drive_up(5'd20, 8'd50, 32'h1111);
    step();
    chk_lane("R8 first", o0_vld, o0_idx, o0_tag, o0_val, 1'b1, 5'd20, 8'd50, 32'h1111);
    drive_up(5'd20, 8'd52, 32'h2222);
    step();
    chk_lane("R8 refreshed", o0_vld, o0_idx, o0_tag, o0_val, 1'b1, 5'd20, 8'd52, 32'h2222);
    drive_up(5'd20, 8'd51, 32'h3333);
    step();
    chk_lane("R8 stale dropped", o0_vld, o0_idx, o0_tag, o0_val, 1'b0, 5'd0, 8'd0, 32'd0);
    idle_in();
    lookup("R8 stored kept", 5'd20, 1'b1, 8'd52, 32'h2222);

    // R6: bulk load with concurrent writes
    for (int r = 0; r < NREG; r++) begin
      init_val[r*DW +: DW] = 32'(r * 3);
      init_tag[r*TW +: TW] = 8'(r);
      init_known[r]        = (r % 2) == 0;
    end
    init_load = 1'b1;
    drive_up(5'd2, 8'd1, 32'hDEAD);
    loc_vld = 1'b1; loc_idx = 5'd4; loc_tag = 8'd100; loc_val = 32'hBEEF;
    step();
    idle_in();
    chk_lane("R6 lane0", o0_vld, o0_idx, o0_tag, o0_val, 1'b1, 5'd4, 8'd100, 32'hBEEF);
    chk("R6 lane1", {63'd0, o1_vld}, 64'd0);
    lookup("R6 r2 loaded", 5'd2, 1'b1, 8'd2, 32'd6);
    lookup("R6 r3 loaded unwritten", 5'd3, 1'b0, 8'd0, 32'd0);
    lookup("R6 r20 replaced", 5'd20, 1'b1, 8'd20, 32'd60);
    lookup("R6 r4 write on top", 5'd4, 1'b1, 8'd100, 32'hBEEF);

    // R1: reset in mid-run clears written flags and lanes
    drive_up(5'd6, 8'd90, 32'h55);
    @(posedge clk);
    #2 rst_n = 1'b0;
    idle_in();
    #1;
    chk("R1 lanes after reset", {62'd0, o1_vld, o0_vld}, 64'd0);
    lookup("R1 r6 cleared", 5'd6, 1'b0, 8'd0, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL timeout act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule